// File: doc/BRIEF.md
# Carrier Clock Divider with Phase Trim

This block divides an incoming carrier clock by a programmable ratio and produces two waveform outputs from one free-running up-counter. The counter runs on the carrier clock itself, counts from 0 up to the active period value C, and then returns to 0, so one output period spans C+1 carrier cycles. Output A turns on at the A compare point and off at the period wrap. Output B turns on at a rising edge of an external event input and off at the B compare point. When output A is wired back into the event input, output B becomes a divided carrier with close to half-period width.

Software drives the block through a single command port, one command per cycle. A ratio load places the period and both compare points in one step. A signed phase step moves both compare points together, modulo the period. Both commands write a pending copy, and the counter takes up the pending copy only at the next period wrap or at a start command, so no period is cut short. A small controller with three states decides when the counter runs. HALT: the clock is disabled and the counter holds its value. ARMED: the clock is enabled and the counter still holds, waiting for a start. RUN: the counter counts. The transitions are: HALT to ARMED on clock-enable; ARMED to RUN on start; RUN to RUN on start, which restarts the count from zero; any state to HALT on clock-disable. A start in HALT is ignored.

Top module: `carrier_div`

## Requirements
- R1: After reset the controller is in HALT, both outputs are low, the count is 0, the active period is 128, compare A is 1 and compare B is 65.
- R2: A ratio load command (code 1, value D on cmd_data) sets the pending period to D, pending compare A to 1 and pending compare B to 1 + floor(D/2).
- R3: In RUN the count rises by one each carrier cycle and goes from the period value back to 0, so the sequence after a start is 0, 1, ..., C, 0, ...
- R4: Output A goes high in the cycle after the count equals compare A and goes low in the cycle after the count equals the period.
- R5: Output B goes high on the third clock edge after a rising edge of evt_in (two-stage synchronizer plus edge detect), once per rising edge, and goes low in the cycle after the count equals compare B.
- R6: When a set and a clear act on one output in the same cycle, the output ends up low.
- R7: A trigger command (code 4) drives both outputs low on the next edge in any state.
- R8: A phase step command (code 2, signed two's-complement step on cmd_data) sets each pending compare point to (old value + step) modulo the pending period, with a result in 0 to period-1, also for negative steps and steps larger than the period.
- R9: If a phase step would leave compare A at 0, compare A becomes 1 and compare B is incremented by one more; compare A is never 0.
- R10: The active period and compare points change only at a period wrap in RUN or at an accepted start; a command given mid-period leaves them unchanged until then.
- R11: Clock-enable (code 5), start (code 3) and clock-disable (code 6) follow the HALT/ARMED/RUN transitions above; in HALT and ARMED the count holds; an accepted start sets the count to 0, loads the pending settings and clears both outputs; a start in HALT changes nothing.
- R12: A ratio value below 2 is replaced by 2 before it is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code: 1 ratio, 2 phase step, 3 start, 4 trigger, 5 clock enable, 6 clock disable |
| cmd_data | input | 16 | Ratio value or signed phase step |
| evt_in | input | 1 | Asynchronous event input that sets output B on a rising edge |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| count_o | output | 16 | Current counter value |
| period_o | output | 16 | Active period compare value |
| cmp_a_o | output | 16 | Active compare A value |
| cmp_b_o | output | 16 | Active compare B value |

## Verification
The checker watches, on every cycle, the counter's step-or-wrap rule, the counter holding in HALT, output A falling after a wrap, both outputs falling after a trigger, the active settings staying put between wraps, a nonzero compare A and a period of at least two. What the per-cycle properties cannot show, the directed scenarios cover: the exact compare values reached by ratio loads and chains of positive, negative and oversized phase steps, the three-edge latency of the event path and its single-set-per-edge behaviour, the timed collision of an event set with a compare-B clear, and a start being ignored while halted.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RATIO   = 3'd1,
        OP_PHASE   = 3'd2,
        OP_START   = 3'd3,
        OP_TRIG    = 3'd4,
        OP_CLK_ON  = 3'd5,
        OP_CLK_OFF = 3'd6
    } cdiv_op_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } cdiv_state_e;

endpackage

// File: rtl/cdiv_evt_sync.sv
`timescale 1ns/1ps
module cdiv_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detect
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], evt_i};
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/cdiv_shadow.sv
`timescale 1ns/1ps
module cdiv_shadow #(
    parameter int W         = 16,
    parameter int DEF_RATIO = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_ratio,
    input  logic         ld_step,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] pend_c_o,
    output logic [W-1:0] pend_a_o,
    output logic [W-1:0] pend_b_o
);
    localparam int SW = W + 2;
    localparam logic [W-1:0] MIN_RATIO = W'(2);
    localparam logic [W-1:0] RST_C     = W'(DEF_RATIO);
    localparam logic [W-1:0] RST_B     = W'(1 + DEF_RATIO / 2);

    logic [W-1:0] ratio_cl;
    logic [W-1:0] step_a, step_b;

    // (v + inc) reduced into 0 .. m-1 for any signed inc
    function automatic logic [W-1:0] mod_add(
        input logic [W-1:0] v,
        input logic [W-1:0] inc,
        input logic [W-1:0] m
    );
        logic signed [SW-1:0] sum, md, rem;
        sum = $signed({2'b00, v}) + $signed({{2{inc[W-1]}}, inc});
        md  = $signed({2'b00, m});
        rem = sum % md;
        if (rem < 0) begin
            rem = rem + md;
        end
        return rem[W-1:0];
    endfunction

    always_comb begin
        ratio_cl = (data_i < MIN_RATIO) ? MIN_RATIO : data_i;
        step_a   = mod_add(pend_a_o, data_i, pend_c_o);
        step_b   = mod_add(pend_b_o, data_i, pend_c_o);
        if (step_a == '0) begin
            step_a = W'(1);
            step_b = step_b + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_c_o <= RST_C;
            pend_a_o <= W'(1);
            pend_b_o <= RST_B;
        end else if (ld_ratio) begin
            pend_c_o <= ratio_cl;
            pend_a_o <= W'(1);
            pend_b_o <= W'(1) + (ratio_cl >> 1);
        end else if (ld_step) begin
            pend_a_o <= step_a;
            pend_b_o <= step_b;
        end
    end

endmodule

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
    import cdiv_pkg::*;
#(
    parameter int W         = 16,
    parameter int DEF_RATIO = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_start,
    input  logic         go_en,
    input  logic         go_dis,
    input  logic [W-1:0] pend_c_i,
    input  logic [W-1:0] pend_a_i,
    input  logic [W-1:0] pend_b_i,
    output cdiv_state_e  state_o,
    output logic         start_o,
    output logic         wrap_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] act_c_o,
    output logic [W-1:0] act_a_o,
    output logic [W-1:0] act_b_o
);
    localparam logic [W-1:0] RST_C = W'(DEF_RATIO);
    localparam logic [W-1:0] RST_B = W'(1 + DEF_RATIO / 2);

    cdiv_state_e state_q, state_d;
    logic        run;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (go_en)    state_d = ST_ARMED;
            ST_ARMED: if (go_start) state_d = ST_RUN;
            ST_RUN:                 state_d = ST_RUN;
            default:                state_d = ST_HALT;
        endcase
        if (go_dis) begin
            state_d = ST_HALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the controller
    assign run     = (state_q == ST_RUN);
    assign start_o = go_start && (state_q != ST_HALT);
    assign wrap_o  = run && (cnt_o == act_c_o);
    assign state_o = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            act_c_o <= RST_C;
            act_a_o <= W'(1);
            act_b_o <= RST_B;
        end else begin
            if (start_o || wrap_o) begin
                cnt_o   <= '0;
                act_c_o <= pend_c_i;
                act_a_o <= pend_a_i;
                act_b_o <= pend_b_i;
            end else if (run) begin
                cnt_o <= cnt_o + W'(1);
            end
        end
    end

endmodule

// File: rtl/cdiv_wave.sv
`timescale 1ns/1ps
module cdiv_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hit_a_i,
    input  logic hit_b_i,
    input  logic hit_c_i,
    input  logic evt_rise_i,
    input  logic clr_i,
    output logic wave_a_o,
    output logic wave_b_o
);
    logic set_a, clr_a, set_b, clr_b;

    assign set_a = run_i && hit_a_i;
    assign clr_a = clr_i || (run_i && hit_c_i);
    assign set_b = run_i && evt_rise_i;
    assign clr_b = clr_i || (run_i && hit_b_i);

    // clear takes priority over set on both outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_a_o <= 1'b0;
            wave_b_o <= 1'b0;
        end else begin
            if (clr_a)      wave_a_o <= 1'b0;
            else if (set_a) wave_a_o <= 1'b1;
            if (clr_b)      wave_b_o <= 1'b0;
            else if (set_b) wave_b_o <= 1'b1;
        end
    end

endmodule

// File: rtl/carrier_div.sv
`timescale 1ns/1ps
module carrier_div
    import cdiv_pkg::*;
#(
    parameter int W           = 16,
    parameter int DEF_RATIO   = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    input  logic         evt_in,
    output logic         wave_a,
    output logic         wave_b,
    output logic [W-1:0] count_o,
    output logic [W-1:0] period_o,
    output logic [W-1:0] cmp_a_o,
    output logic [W-1:0] cmp_b_o
);
    cdiv_state_e  state;
    logic         ld_ratio, ld_step, go_start, go_en, go_dis, trig;
    logic         start_ok, wrap, evt_rise, run;
    logic [W-1:0] pend_c, pend_a, pend_b;

    assign ld_ratio = cmd_valid && (cmd_op == OP_RATIO);
    assign ld_step  = cmd_valid && (cmd_op == OP_PHASE);
    assign go_start = cmd_valid && (cmd_op == OP_START);
    assign trig     = cmd_valid && (cmd_op == OP_TRIG);
    assign go_en    = cmd_valid && (cmd_op == OP_CLK_ON);
    assign go_dis   = cmd_valid && (cmd_op == OP_CLK_OFF);
    assign run      = (state == ST_RUN);

    cdiv_shadow #(.W(W), .DEF_RATIO(DEF_RATIO)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ratio (ld_ratio),
        .ld_step  (ld_step),
        .data_i   (cmd_data),
        .pend_c_o (pend_c),
        .pend_a_o (pend_a),
        .pend_b_o (pend_b)
    );

    cdiv_ctrl #(.W(W), .DEF_RATIO(DEF_RATIO)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_start (go_start),
        .go_en    (go_en),
        .go_dis   (go_dis),
        .pend_c_i (pend_c),
        .pend_a_i (pend_a),
        .pend_b_i (pend_b),
        .state_o  (state),
        .start_o  (start_ok),
        .wrap_o   (wrap),
        .cnt_o    (count_o),
        .act_c_o  (period_o),
        .act_a_o  (cmp_a_o),
        .act_b_o  (cmp_b_o)
    );

    cdiv_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_in),
        .rise_o (evt_rise)
    );

    cdiv_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .hit_a_i    (count_o == cmp_a_o),
        .hit_b_i    (count_o == cmp_b_o),
        .hit_c_i    (wrap),
        .evt_rise_i (evt_rise),
        .clr_i      (trig || start_ok),
        .wave_a_o   (wave_a),
        .wave_b_o   (wave_b)
    );

endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk
    import cdiv_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input cdiv_state_e  state,
    input logic         start_ok,
    input logic         trig,
    input logic         wave_a,
    input logic         wave_b,
    input logic [W-1:0] count_o,
    input logic [W-1:0] period_o,
    input logic [W-1:0] cmp_a_o,
    input logic [W-1:0] cmp_b_o
);
    logic run;
    assign run = (state == ST_RUN);

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && (count_o == period_o) |=> count_o == '0);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !start_ok && (count_o != period_o) |=> count_o == $past(count_o) + W'(1));

    // R4
    a_low_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && (count_o == period_o) |=> !wave_a);

    // R7
    trig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !wave_a && !wave_b);

    // R9
    cmp_a_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_a_o != '0);

    // R12
    period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_o >= W'(2));

    // R10
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ok && !(run && (count_o == period_o))
        |=> $stable(period_o) && $stable(cmp_a_o) && $stable(cmp_b_o));

    // R11
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |=> $stable(count_o));

endmodule

bind carrier_div cdiv_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .start_ok (start_ok),
    .trig     (trig),
    .wave_a   (wave_a),
    .wave_b   (wave_b),
    .count_o  (count_o),
    .period_o (period_o),
    .cmp_a_o  (cmp_a_o),
    .cmp_b_o  (cmp_b_o)
);

// File: tb/carrier_div_tb.sv
`timescale 1ns/1ps
module carrier_div_tb;
    import cdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        evt_in = 1'b0;
    logic        wave_a, wave_b;
    logic [15:0] count_o, period_o, cmp_a_o, cmp_b_o;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    carrier_div u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .evt_in    (evt_in),
        .wave_a    (wave_a),
        .wave_b    (wave_b),
        .count_o   (count_o),
        .period_o  (period_o),
        .cmp_a_o   (cmp_a_o),
        .cmp_b_o   (cmp_b_o)
    );

    task automatic check(input string req, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // issue a command at the current falling edge; returns one cycle later
    task automatic cmd_now(input cdiv_op_e op, input logic [15:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
        cmd_data  = 16'd0;
    endtask

    task automatic cmd(input cdiv_op_e op, input logic [15:0] d);
        @(negedge clk);
        cmd_now(op, d);
    endtask

    task automatic wait_cnt(input int v);
        while (count_o != 16'(v)) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 wave_a", int'(wave_a), 0);
        check("R1 wave_b", int'(wave_b), 0);
        check("R1 count", int'(count_o), 0);
        check("R1 period", int'(period_o), 128);
        check("R1 cmp_a", int'(cmp_a_o), 1);
        check("R1 cmp_b", int'(cmp_b_o), 65);
        repeat (3) @(negedge clk);
        check("R11 halted count holds", int'(count_o), 0);
    endtask

    task automatic t_start();
        cmd(OP_RATIO, 16'd10);
        check("R10 ratio pending only", int'(period_o), 128);
        cmd(OP_START, 16'd0);
        repeat (3) @(negedge clk);
        check("R11 start ignored in halt: count", int'(count_o), 0);
        check("R11 start ignored in halt: period", int'(period_o), 128);
        cmd(OP_CLK_ON, 16'd0);
        repeat (3) @(negedge clk);
        check("R11 armed count holds", int'(count_o), 0);
        cmd(OP_START, 16'd0);
        check("R2 period", int'(period_o), 10);
        check("R2 cmp_a", int'(cmp_a_o), 1);
        check("R2 cmp_b", int'(cmp_b_o), 6);
        check("R11 start count", int'(count_o), 0);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            check("R3 count sequence", int'(count_o), k % 11);
            check("R4 wave_a shape", int'(wave_a), (count_o >= 16'd2) ? 1 : 0);
        end
    endtask

    task automatic t_event();
        wait_cnt(0);
        evt_in = 1'b1;
        wait_cnt(3);
        check("R5 wave_b set latency", int'(wave_b), 1);
        wait_cnt(6);
        check("R5 wave_b held", int'(wave_b), 1);
        @(negedge clk);
        check("R5 wave_b cleared after B", int'(wave_b), 0);
        wait_cnt(3);
        check("R5 level does not re-set", int'(wave_b), 0);
        evt_in = 1'b0;
        wait_cnt(0);
        wait_cnt(4);
        evt_in = 1'b1;
        wait_cnt(7);
        check("R6 set vs clear on B", int'(wave_b), 0);
        evt_in = 1'b0;
    endtask

    task automatic t_trig();
        wait_cnt(5);
        check("R4 wave_a high mid period", int'(wave_a), 1);
        cmd_now(OP_TRIG, 16'd0);
        check("R7 trig clears A", int'(wave_a), 0);
        check("R7 trig clears B", int'(wave_b), 0);
        wait_cnt(9);
        check("R7 A stays low", int'(wave_a), 0);
        wait_cnt(2);
        check("R4 A set again", int'(wave_a), 1);
        wait_cnt(1);
        cmd_now(OP_TRIG, 16'd0);
        check("R6 trig vs set on A", int'(wave_a), 0);
    endtask

    task automatic t_phase();
        wait_cnt(2);
        cmd_now(OP_PHASE, 16'd3);
        check("R10 step pending only", int'(cmp_a_o), 1);
        wait_cnt(0);
        check("R8 +3 cmp_a", int'(cmp_a_o), 4);
        check("R8 +3 cmp_b", int'(cmp_b_o), 9);
        wait_cnt(2);
        cmd_now(OP_PHASE, 16'hFFFC);
        wait_cnt(0);
        check("R9 zero skip cmp_a", int'(cmp_a_o), 1);
        check("R9 zero skip cmp_b", int'(cmp_b_o), 6);
        wait_cnt(2);
        cmd_now(OP_PHASE, 16'hFFFD);
        wait_cnt(0);
        check("R8 -3 cmp_a", int'(cmp_a_o), 8);
        check("R8 -3 cmp_b", int'(cmp_b_o), 3);
        wait_cnt(2);
        cmd_now(OP_PHASE, 16'd25);
        wait_cnt(0);
        check("R8 +25 cmp_a", int'(cmp_a_o), 3);
        check("R8 +25 cmp_b", int'(cmp_b_o), 8);
    endtask

    task automatic t_clamp();
        wait_cnt(2);
        cmd_now(OP_RATIO, 16'd1);
        wait_cnt(0);
        check("R12 ratio 1 period", int'(period_o), 2);
        check("R12 ratio 1 cmp_a", int'(cmp_a_o), 1);
        check("R12 ratio 1 cmp_b", int'(cmp_b_o), 2);
        cmd(OP_RATIO, 16'd0);
        repeat (8) @(negedge clk);
        check("R12 ratio 0 period", int'(period_o), 2);
        cmd(OP_RATIO, 16'd11);
        repeat (8) @(negedge clk);
        check("R2 odd ratio period", int'(period_o), 11);
        check("R2 odd ratio cmp_b", int'(cmp_b_o), 6);
    endtask

    task automatic t_halt();
        int v;
        cmd(OP_CLK_OFF, 16'd0);
        v = int'(count_o);
        repeat (5) @(negedge clk);
        check("R11 halt holds count", int'(count_o), v);
        cmd(OP_CLK_ON, 16'd0);
        repeat (3) @(negedge clk);
        check("R11 armed holds count", int'(count_o), v);
        cmd(OP_START, 16'd0);
        check("R11 restart count", int'(count_o), 0);
        @(negedge clk);
        check("R11 counting after restart", int'(count_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_event();
        t_trig();
        t_phase();
        t_clamp();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule